// File: doc/BRIEF.md
# Shared Indirect Register Window with Ownership Locks

This block is a small register window that several requesters share to reach a larger internal register store without mapping it directly. A requester picks an address space through a control register, posts a target address into an address register and moves 32-bit values through a data register. A handshake bit at the top of the address register shows whether the indirect operation is still in flight. The operation itself takes a configurable number of cycles.

Coordination between requesters rests on a free-running ID counter and two kinds of lock. The first is a gateway lock held in the window itself. The second is a set of lock words inside a dedicated semaphore address space. A requester reads the counter to get a unique nonzero ID and writes that ID into a lock. It owns the lock only if reading the lock back returns its own ID. Writing zero hands the lock back.

Top module: `reg_gateway`

## Requirements
- R1: After reset the control, gateway-lock, address and data registers read 0, and the first counter read returns 1.
- R2: A read of the counter (offset 0x8) returns its current value and then advances it by one. From its all-ones value (parameter CNT_W bits) it steps to 1, so it never returns 0.
- R3: The gateway lock (offset 0xC) takes a nonzero write only while it holds 0. A nonzero write while it is held is ignored, and a write of 0 always clears it.
- R4: The control register (offset 0x4) reads back the space selector written into bits 15:0. Bits 31:29 read 3'b001 when the selector is 0x2, 0x6 or 0xA and 3'b000 otherwise. All other bits read 0.
- R5: Indirect write: after the data register (offset 0x14) is loaded, writing the address register (offset 0x10) with bit 31 = 1 starts the write. Bit 31 reads 1 until exactly LAT clock edges after the posting edge, then reads 0 with the value stored.
- R6: Indirect read: writing the address register with bit 31 = 0 starts a read. Bit 31 reads 0 until exactly LAT edges after the posting edge, then reads 1 with the data register holding the stored word.
- R7: Spaces 0x2, 0x6 and 0xA each hold their own DEPTH words, indexed by address bits above bit 1. The same address in different spaces names different words.
- R8: In space 0xA, a nonzero write to a word that already holds a nonzero value is ignored, and a write of 0 clears it. This is the case for the software-reset lock word at address 0x20, so the read-back decides ownership.
- R9: While an unsupported space is selected, indirect writes change no stored word and indirect reads return 0.
- R10: While an indirect operation is in flight, writes to the control, address and data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the counter side effect) |
| reg_addr | input | 5 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
Register reads are combinational, so values are sampled 1 ns after the inputs settle at a falling edge. Side effects of a write or a counter read show up 1 ns after the following rising edge. An indirect operation is posted at a rising edge. The bench then counts rising edges while polling bit 31 and requires the flip after exactly LAT edges, for every read and write in the sweeps. The in-flight lockout is tested by issuing writes on the edges inside that window, including the completing edge. The results are checked only after the flag has flipped.

// File: rtl/reg_gateway.sv
module reg_gateway #(
  parameter int LAT   = 4,
  parameter int DEPTH = 16,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IW = $clog2(DEPTH);
  localparam int WW = $clog2(LAT + 1);
  localparam logic [4:0] OFS_CTRL = 5'h04, OFS_CNT = 5'h08, OFS_LOCK = 5'h0C,
                         OFS_ADDR = 5'h10, OFS_DATA = 5'h14;

  logic [15:0]      space_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      gsem_q, data_q, cnt_rd, cur_word;
  logic [30:0]      ia_q;
  logic             flag_q, busy_q, op_wr_q, sp_ok, done;
  logic [1:0]       sp_idx;
  logic [WW-1:0]    wait_q;
  logic [31:0]      mem [3][DEPTH];
  logic [IW-1:0]    widx;

  always_comb begin
    sp_ok  = 1'b1;
    sp_idx = 2'd0;
    case (space_q)
      16'h0002: sp_idx = 2'd0;
      16'h0006: sp_idx = 2'd1;
      16'h000A: sp_idx = 2'd2;
      default:  sp_ok  = 1'b0;
    endcase
  end

  assign widx     = ia_q[IW+1:2];
  assign cur_word = sp_ok ? mem[sp_idx][widx] : 32'd0;
  assign done     = busy_q && (wait_q == '0);
  assign cnt_rd   = 32'(cnt_q);

  wire wr_ok = reg_wr && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      space_q <= '0;
      cnt_q   <= CNT_W'(1);
      gsem_q  <= '0;
      data_q  <= '0;
      ia_q    <= '0;
      flag_q  <= 1'b0;
      busy_q  <= 1'b0;
      op_wr_q <= 1'b0;
      wait_q  <= '0;
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < DEPTH; w++) mem[s][w] <= '0;
    end else begin
      if (reg_rd && reg_addr == OFS_CNT)
        cnt_q <= (cnt_q == '1) ? CNT_W'(1) : cnt_q + 1'b1;
      if (reg_wr && reg_addr == OFS_LOCK)
        if (reg_wdata == '0 || gsem_q == '0) gsem_q <= reg_wdata;
      if (wr_ok && reg_addr == OFS_CTRL) space_q <= reg_wdata[15:0];
      if (wr_ok && reg_addr == OFS_DATA) data_q <= reg_wdata;
      if (wr_ok && reg_addr == OFS_ADDR) begin
        ia_q    <= reg_wdata[30:0];
        flag_q  <= reg_wdata[31];
        op_wr_q <= reg_wdata[31];
        busy_q  <= 1'b1;
        wait_q  <= WW'(LAT - 1);
      end
      if (busy_q && !done) wait_q <= wait_q - 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        flag_q <= !op_wr_q;
        if (!op_wr_q) data_q <= cur_word;
        else if (sp_ok && !(sp_idx == 2'd2 && data_q != '0 && cur_word != '0))
          mem[sp_idx][widx] <= data_q;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = {sp_ok ? 3'b001 : 3'b000, 13'd0, space_q};
      OFS_CNT:  reg_rdata = cnt_rd;
      OFS_LOCK: reg_rdata = gsem_q;
      OFS_ADDR: reg_rdata = {flag_q, ia_q};
      OFS_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/reg_gateway_chk.sv
module reg_gateway_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] cnt_rd,
  input logic [31:0] gsem_q,
  input logic [31:0] data_q,
  input logic [15:0] space_q,
  input logic        flag_q,
  input logic        busy_q,
  input logic        op_wr_q,
  input logic        done,
  input logic        sp_ok
);
  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd != 32'd0); // R2
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'h08) |=> cnt_rd != $past(cnt_rd)); // R2
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (gsem_q != 32'd0 && !(reg_wr && reg_addr == 5'h0C && reg_wdata == 32'd0)) |=> $stable(gsem_q)); // R3
  AST_SPACE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sp_ok |-> (space_q == 16'h2 || space_q == 16'h6 || space_q == 16'hA)); // R4
  AST_FLAG_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (flag_q == op_wr_q)); // R5
  AST_DATA_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done && reg_wr && reg_addr == 5'h14) |=> $stable(data_q)); // R10
  AST_CTRL_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_wr && reg_addr == 5'h04) |=> $stable(space_q)); // R10
endmodule

bind reg_gateway reg_gateway_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cnt_rd(cnt_rd),
  .gsem_q(gsem_q), .data_q(data_q), .space_q(space_q), .flag_q(flag_q),
  .busy_q(busy_q), .op_wr_q(op_wr_q), .done(done), .sp_ok(sp_ok)
);

// File: tb/reg_gateway_tb.sv
`timescale 1ns/1ps
module reg_gateway_tb;
  localparam int LAT = 3, DEPTH = 16, CNT_W = 4;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int total = 0, bad = 0;
  logic [31:0] exp_m [3][DEPTH];

  reg_gateway #(.LAT(LAT), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wait_flag(logic busy_val, string tag);
    int n = 0;
    reg_addr = 5'h10; #1;
    while (reg_rdata[31] === busy_val && n < 50) begin
      @(posedge clk); #1 n++;
    end
    chk(tag, n, LAT);
  endtask

  task automatic ind_wr(logic [30:0] a, logic [31:0] d);
    wr(5'h14, d);
    wr(5'h10, {1'b1, a});
    wait_flag(1'b1, "R5 write latency");
  endtask

  task automatic ind_rd(logic [30:0] a, output logic [31:0] v);
    wr(5'h10, {1'b0, a});
    wait_flag(1'b0, "R6 read latency");
    reg_addr = 5'h14; #1 v = reg_rdata;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired, all R checks incomplete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    for (int s = 0; s < 3; s++) for (int w = 0; w < DEPTH; w++) exp_m[s][w] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    reg_addr = 5'h04; #1 chk("R1 ctrl", reg_rdata, 0);
    reg_addr = 5'h0C; #1 chk("R1 lock", reg_rdata, 0);
    reg_addr = 5'h10; #1 chk("R1 addr", reg_rdata, 0);
    reg_addr = 5'h14; #1 chk("R1 data", reg_rdata, 0);
    rd(5'h08, v); chk("R1 first id", v, 1);

    e = 2;
    for (int i = 0; i < 20; i++) begin
      rd(5'h08, v); chk("R2 counter", v, e);
      e = (e == 15) ? 1 : e + 1;
    end

    wr(5'h0C, 5);  rd(5'h0C, v); chk("R3 acquire", v, 5);
    wr(5'h0C, 9);  rd(5'h0C, v); chk("R3 held", v, 5);
    wr(5'h0C, 0);  rd(5'h0C, v); chk("R3 release", v, 0);
    wr(5'h0C, 9);  rd(5'h0C, v); chk("R3 reacquire", v, 9);
    wr(5'h0C, 0);

    for (int s = 0; s < 17; s++) begin
      logic [15:0] sel = (s == 16) ? 16'h1234 : 16'(s);
      wr(5'h04, {16'hFFFF, sel});
      rd(5'h04, v);
      e = {(sel == 2 || sel == 6 || sel == 16'hA) ? 3'b001 : 3'b000, 13'd0, sel};
      chk("R4 ctrl", v, e);
    end

    wr(5'h04, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin
      ind_wr(31'(i * 4), 32'hA500_0000 + 32'(i * 7));
      exp_m[0][i] = 32'hA500_0000 + 32'(i * 7);
    end
    wr(5'h04, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      ind_wr(31'(i * 4), 32'h6600_0000 ^ 32'(i * 13));
      exp_m[1][i] = 32'h6600_0000 ^ 32'(i * 13);
    end
    for (int i = 0; i < DEPTH; i++) begin
      ind_rd(31'(i * 4), v); chk("R7 space 6", v, exp_m[1][i]);
    end
    wr(5'h04, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin
      ind_rd(31'(i * 4), v); chk("R6 R7 space 2", v, exp_m[0][i]);
    end

    wr(5'h04, 32'hA);
    ind_wr(31'h20, 3); ind_rd(31'h20, v); chk("R8 owner", v, 3);
    ind_wr(31'h20, 7); ind_rd(31'h20, v); chk("R8 ignored", v, 3);
    ind_wr(31'h20, 0); ind_rd(31'h20, v); chk("R8 cleared", v, 0);
    ind_wr(31'h20, 7); ind_rd(31'h20, v); chk("R8 new owner", v, 7);

    wr(5'h04, 32'h5);
    ind_wr(31'h10, 32'hDEAD_BEEF);
    ind_rd(31'h10, v); chk("R9 unsupported read", v, 0);
    wr(5'h04, 32'h2);
    ind_rd(31'h10, v); chk("R9 store untouched", v, exp_m[0][4]);

    wr(5'h10, {1'b0, 31'h8});
    wr(5'h14, 32'h1111_2222);
    wr(5'h10, {1'b1, 31'h3C});
    wr(5'h04, 32'h6);
    reg_addr = 5'h10; #1 chk("R10 flag done", reg_rdata, {1'b1, 31'h8});
    reg_addr = 5'h14; #1 chk("R10 data", reg_rdata, exp_m[0][2]);
    reg_addr = 5'h04; #1 chk("R10 ctrl", reg_rdata, {3'b001, 13'd0, 16'h2});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule